// File: doc/BRIEF.md
# ECC Error Reporting Hub

This block gathers error events from the ECC checkers of up to sixteen memories. Each memory channel raises a correctable (single-bit) strobe or a non-correctable strobe, and presents an error address and a syndrome alongside it. For every channel the hub keeps two sticky status flags, two interrupt enables, the address and syndrome of the latest event, and a count of correctable events. Two interrupt lines leave the block: one for correctable events and one for non-correctable events.

Software reaches all of this through a simple word-indexed register bus. Writes take one cycle and reads are combinational from the index. The index is six bits wide. The upper two bits select a group: 0 is control and status, 1 is addresses, 2 is syndromes and 3 is counters. The lower four bits select the register within the group or the channel number. In group 0, index 0 holds the enables for channels 0 to 7 and index 1 holds the enables for channels 8 to 15. Index 2 holds the flags for channels 0 to 7 and index 3 holds the flags for channels 8 to 15. The per-channel fields are packed in reverse order inside each word.

Top module: `ecc_err_hub`

## Requirements
- R1: In an enable or flag word, channel n owns the nibble at bit (7-n)*4 for channels 0 to 7, or (15-n)*4 for channels 8 to 15. Bit 3 of the nibble is the correctable bit and bit 2 is the non-correctable bit. Bits 1:0 of every nibble read as zero and ignore writes, and all registers read zero after reset.
- R2: A write to enable word 0 or 1 stores bits 3 and 2 of every nibble, and those bits read back unchanged.
- R3: A correctable strobe on a channel sets that channel's correctable flag, and a non-correctable strobe sets its non-correctable flag. Each flag is set from the clock edge that samples the strobe and stays set until software clears it.
- R4: Writing flag word 2 or 3 clears exactly those flags whose bit positions are written as one. Flags written as zero keep their value.
- R5: If a strobe arrives in the same cycle as a clear of that flag, the flag stays set.
- R6: Every event, of either kind, overwrites the channel's address register (index 16+n) and syndrome register (index 32+n) with the values presented with that event.
- R7: The channel's counter (index 48+n) increases by one on each correctable event. Non-correctable events leave it unchanged.
- R8: The counter saturates at 255 and stays there on further correctable events.
- R9: Writing zero to a counter resets it to 0. A non-zero write has no effect. A zero write in the same cycle as a correctable event leaves the counter at 1.
- R10: irq_corr is high exactly when some channel has both its correctable flag and its correctable enable set. irq_fatal behaves the same way for the non-correctable flag and enable.
- R11: A cycle in which both strobes of a channel are high sets both of its flags and counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_idx | input | 6 | Register index: group in bits 5:4, register or channel in bits 3:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx |
| ev_corr | input | NUM_CH | Correctable event strobe, one bit per channel |
| ev_fatal | input | NUM_CH | Non-correctable event strobe, one bit per channel |
| ev_addr | input | NUM_CH*ADDR_W | Error address per channel, with channel n in slice n |
| ev_syn | input | NUM_CH*SYN_W | Syndrome per channel, with channel n in slice n |
| irq_corr | output | 1 | Correctable interrupt |
| irq_fatal | output | 1 | Non-correctable interrupt |

## Verification
The bound checker watches every channel on every cycle for the following:
- a strobe always sets its flag, which covers the race with a clear;
- a flag survives unless its own bit is written with a one;
- address capture follows every event;
- non-correctable events leave the counter alone;
- a full counter never wraps;
- each interrupt line follows its enabled flags.

Some properties depend on the register layout and on software sequences, so only the directed scenarios can show them:
- the reversed nibble packing and the zero bits 1:0;
- read-back of the enables;
- overwrite by a later event;
- the counter's zero-write reset, including the case where it coincides with an event.

// File: rtl/ecc_err_pkg.sv
`timescale 1ns/1ps
package ecc_err_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned IDX_W      = 6;
   localparam int unsigned CH_PER_REG = 8;
   localparam int unsigned MAX_CH     = 16;
   localparam int unsigned NIB_CORR   = 3;
   localparam int unsigned NIB_FATAL  = 2;

   typedef enum logic [1:0] {
      GRP_CTRL = 2'd0,
      GRP_ADDR = 2'd1,
      GRP_SYN  = 2'd2,
      GRP_CNT  = 2'd3
   } grp_e;

   // lowest bit of channel ch's nibble inside its word (reverse packing)
   function automatic int unsigned nib_lsb(input int unsigned ch);
      return (CH_PER_REG - 1 - (ch % CH_PER_REG)) * 4;
   endfunction

   // which of the two words holds channel ch
   function automatic int unsigned word_of(input int unsigned ch);
      return ch / CH_PER_REG;
   endfunction
endpackage

// File: rtl/ecc_err_satcnt.sv
`timescale 1ns/1ps
module ecc_err_satcnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= inc ? CNT_ONE : '0;
      end else if (inc && (cnt != CNT_MAX)) begin
         cnt <= cnt + CNT_ONE;
      end
   end
endmodule

// File: rtl/ecc_err_chan.sv
`timescale 1ns/1ps
module ecc_err_chan #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SYN_W  = 8,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_corr,
   input  logic              ev_fatal,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [SYN_W-1:0]  ev_syn,
   input  logic              en_we,
   input  logic              en_corr_d,
   input  logic              en_fatal_d,
   input  logic              clr_corr,
   input  logic              clr_fatal,
   input  logic              cnt_clr,
   output logic              en_corr,
   output logic              en_fatal,
   output logic              fl_corr,
   output logic              fl_fatal,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [SYN_W-1:0]  cap_syn,
   output logic [CNT_W-1:0]  err_cnt
);
   logic ev_any;
   assign ev_any = ev_corr | ev_fatal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_corr  <= 1'b0;
         en_fatal <= 1'b0;
      end else if (en_we) begin
         en_corr  <= en_corr_d;
         en_fatal <= en_fatal_d;
      end
   end

   // set has priority over write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_corr  <= 1'b0;
         fl_fatal <= 1'b0;
      end else begin
         fl_corr  <= ev_corr  | (fl_corr  & ~clr_corr);
         fl_fatal <= ev_fatal | (fl_fatal & ~clr_fatal);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr <= '0;
         cap_syn  <= '0;
      end else if (ev_any) begin
         cap_addr <= ev_addr;
         cap_syn  <= ev_syn;
      end
   end

   ecc_err_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev_corr),
      .clr   (cnt_clr),
      .cnt   (err_cnt)
   );
endmodule

// File: rtl/ecc_err_rdmux.sv
`timescale 1ns/1ps
module ecc_err_rdmux
   import ecc_err_pkg::*;
#(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SYN_W  = 8,
   parameter int unsigned CNT_W  = 8
) (
   input  logic [IDX_W-1:0]         idx,
   input  logic [NUM_CH-1:0]        en_c,
   input  logic [NUM_CH-1:0]        en_f,
   input  logic [NUM_CH-1:0]        fl_c,
   input  logic [NUM_CH-1:0]        fl_f,
   input  logic [NUM_CH*ADDR_W-1:0] addr_flat,
   input  logic [NUM_CH*SYN_W-1:0]  syn_flat,
   input  logic [NUM_CH*CNT_W-1:0]  cnt_flat,
   output logic [REG_W-1:0]         rdata
);
   logic [REG_W-1:0] en_word  [2];
   logic [REG_W-1:0] fl_word  [2];
   grp_e             grp;
   logic [3:0]       sel;
   logic             ch_ok;

   assign grp   = grp_e'(idx[5:4]);
   assign sel   = idx[3:0];
   assign ch_ok = int'(sel) < NUM_CH;

   always_comb begin
      en_word[0] = '0;
      en_word[1] = '0;
      fl_word[0] = '0;
      fl_word[1] = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         en_word[word_of(c)][nib_lsb(c) + NIB_CORR]  = en_c[c];
         en_word[word_of(c)][nib_lsb(c) + NIB_FATAL] = en_f[c];
         fl_word[word_of(c)][nib_lsb(c) + NIB_CORR]  = fl_c[c];
         fl_word[word_of(c)][nib_lsb(c) + NIB_FATAL] = fl_f[c];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (grp)
         GRP_CTRL: begin
            case (sel)
               4'd0:    rdata = en_word[0];
               4'd1:    rdata = en_word[1];
               4'd2:    rdata = fl_word[0];
               4'd3:    rdata = fl_word[1];
               default: rdata = '0;
            endcase
         end
         GRP_ADDR: if (ch_ok) rdata[ADDR_W-1:0] = addr_flat[sel*ADDR_W +: ADDR_W];
         GRP_SYN:  if (ch_ok) rdata[SYN_W-1:0]  = syn_flat[sel*SYN_W +: SYN_W];
         GRP_CNT:  if (ch_ok) rdata[CNT_W-1:0]  = cnt_flat[sel*CNT_W +: CNT_W];
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_err_hub.sv
`timescale 1ns/1ps
module ecc_err_hub
   import ecc_err_pkg::*;
#(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SYN_W  = 8,
   parameter int unsigned CNT_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic [5:0]               bus_idx,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   input  logic [NUM_CH-1:0]        ev_corr,
   input  logic [NUM_CH-1:0]        ev_fatal,
   input  logic [NUM_CH*ADDR_W-1:0] ev_addr,
   input  logic [NUM_CH*SYN_W-1:0]  ev_syn,
   output logic                     irq_corr,
   output logic                     irq_fatal
);
   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("NUM_CH must lie in 1..16");
      end
      if (ADDR_W < 1 || ADDR_W > REG_W) begin : g_bad_addr
         $error("ADDR_W must lie in 1..32");
      end
      if (SYN_W < 1 || SYN_W > REG_W) begin : g_bad_syn
         $error("SYN_W must lie in 1..32");
      end
      if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
         $error("CNT_W must lie in 1..32");
      end
   endgenerate

   logic [NUM_CH-1:0]        en_c, en_f, fl_c, fl_f;
   logic [NUM_CH*ADDR_W-1:0] addr_flat;
   logic [NUM_CH*SYN_W-1:0]  syn_flat;
   logic [NUM_CH*CNT_W-1:0]  cnt_flat;
   grp_e                     grp;
   logic [3:0]               sel;

   assign grp = grp_e'(bus_idx[5:4]);
   assign sel = bus_idx[3:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int unsigned WRD = word_of(c);
      localparam int unsigned LSB = nib_lsb(c);
      logic en_we, fl_we, cnt_clr;

      assign en_we   = bus_wr && (grp == GRP_CTRL) && (sel == 4'(WRD));
      assign fl_we   = bus_wr && (grp == GRP_CTRL) && (sel == 4'(WRD + 2));
      assign cnt_clr = bus_wr && (grp == GRP_CNT) && (sel == 4'(c)) && (bus_wdata == '0);

      ecc_err_chan #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .CNT_W(CNT_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .ev_corr    (ev_corr[c]),
         .ev_fatal   (ev_fatal[c]),
         .ev_addr    (ev_addr[c*ADDR_W +: ADDR_W]),
         .ev_syn     (ev_syn[c*SYN_W +: SYN_W]),
         .en_we      (en_we),
         .en_corr_d  (bus_wdata[LSB + NIB_CORR]),
         .en_fatal_d (bus_wdata[LSB + NIB_FATAL]),
         .clr_corr   (fl_we & bus_wdata[LSB + NIB_CORR]),
         .clr_fatal  (fl_we & bus_wdata[LSB + NIB_FATAL]),
         .cnt_clr    (cnt_clr),
         .en_corr    (en_c[c]),
         .en_fatal   (en_f[c]),
         .fl_corr    (fl_c[c]),
         .fl_fatal   (fl_f[c]),
         .cap_addr   (addr_flat[c*ADDR_W +: ADDR_W]),
         .cap_syn    (syn_flat[c*SYN_W +: SYN_W]),
         .err_cnt    (cnt_flat[c*CNT_W +: CNT_W])
      );
   end

   ecc_err_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SYN_W(SYN_W), .CNT_W(CNT_W)) u_rdmux (
      .idx       (bus_idx),
      .en_c      (en_c),
      .en_f      (en_f),
      .fl_c      (fl_c),
      .fl_f      (fl_f),
      .addr_flat (addr_flat),
      .syn_flat  (syn_flat),
      .cnt_flat  (cnt_flat),
      .rdata     (bus_rdata)
   );

   assign irq_corr  = |(fl_c & en_c);
   assign irq_fatal = |(fl_f & en_f);
endmodule

// File: rtl/ecc_err_hub_chk.sv
`timescale 1ns/1ps
module ecc_err_hub_chk
   import ecc_err_pkg::*;
#(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_wr,
   input logic [5:0]               bus_idx,
   input logic [31:0]              bus_wdata,
   input logic [NUM_CH-1:0]        ev_corr,
   input logic [NUM_CH-1:0]        ev_fatal,
   input logic [NUM_CH*ADDR_W-1:0] ev_addr,
   input logic                     irq_corr,
   input logic                     irq_fatal,
   input logic [NUM_CH-1:0]        en_c,
   input logic [NUM_CH-1:0]        en_f,
   input logic [NUM_CH-1:0]        fl_c,
   input logic [NUM_CH-1:0]        fl_f,
   input logic [NUM_CH*ADDR_W-1:0] addr_flat,
   input logic [NUM_CH*CNT_W-1:0]  cnt_flat
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   AST_IRQ_CORR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_c == '0) |-> !irq_corr); // R10
   AST_IRQ_FATAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_f == '0) |-> !irq_fatal); // R10

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      localparam int unsigned LSB = nib_lsb(c);
      localparam logic [5:0] FL_IDX  = 6'(word_of(c) + 2);
      localparam logic [5:0] CNT_IDX = 6'(48 + c);
      logic clr_c, cnt_wr;
      assign clr_c  = bus_wr && (bus_idx == FL_IDX) && bus_wdata[LSB + NIB_CORR];
      assign cnt_wr = bus_wr && (bus_idx == CNT_IDX);

      AST_CORR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         ev_corr[c] |=> fl_c[c]); // R5
      AST_FATAL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         ev_fatal[c] |=> fl_f[c]); // R3
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (fl_c[c] && !clr_c) |=> fl_c[c]); // R4
      AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (fl_c[c] && clr_c && !ev_corr[c]) |=> !fl_c[c]); // R4
      AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_corr[c] || ev_fatal[c]) |=>
            (addr_flat[c*ADDR_W +: ADDR_W] == $past(ev_addr[c*ADDR_W +: ADDR_W]))); // R6
      AST_FATAL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_fatal[c] && !ev_corr[c] && !cnt_wr) |=> $stable(cnt_flat[c*CNT_W +: CNT_W])); // R7
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         ((cnt_flat[c*CNT_W +: CNT_W] == CNT_TOP) && !cnt_wr) |=>
            (cnt_flat[c*CNT_W +: CNT_W] == CNT_TOP)); // R8
      AST_IRQ_CORR_ON: assert property (@(posedge clk) disable iff (!rst_n)
         (fl_c[c] && en_c[c]) |-> irq_corr); // R10
      AST_IRQ_FATAL_ON: assert property (@(posedge clk) disable iff (!rst_n)
         (fl_f[c] && en_f[c]) |-> irq_fatal); // R10
   end
endmodule

bind ecc_err_hub ecc_err_hub_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_idx   (bus_idx),
   .bus_wdata (bus_wdata),
   .ev_corr   (ev_corr),
   .ev_fatal  (ev_fatal),
   .ev_addr   (ev_addr),
   .irq_corr  (irq_corr),
   .irq_fatal (irq_fatal),
   .en_c      (en_c),
   .en_f      (en_f),
   .fl_c      (fl_c),
   .fl_f      (fl_f),
   .addr_flat (addr_flat),
   .cnt_flat  (cnt_flat)
);

// File: tb/ecc_err_hub_tb.sv
`timescale 1ns/1ps
module ecc_err_hub_tb;
   localparam int NCH = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [5:0]        bus_idx = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCH-1:0]    ev_corr = '0;
   logic [NCH-1:0]    ev_fatal = '0;
   logic [NCH*32-1:0] ev_addr = '0;
   logic [NCH*8-1:0]  ev_syn = '0;
   logic              irq_corr, irq_fatal;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   ecc_err_hub u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_idx   (bus_idx),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ev_corr   (ev_corr),
      .ev_fatal  (ev_fatal),
      .ev_addr   (ev_addr),
      .ev_syn    (ev_syn),
      .irq_corr  (irq_corr),
      .irq_fatal (irq_fatal)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // one clock with the given bus write and event strobes, then idle
   task automatic cyc(input logic wr, input logic [5:0] idx, input logic [31:0] wd,
                      input logic [NCH-1:0] cm, input logic [NCH-1:0] fm,
                      input logic [31:0] a, input logic [7:0] s);
      @(negedge clk);
      bus_wr = wr; bus_idx = idx; bus_wdata = wd;
      ev_corr = cm; ev_fatal = fm; ev_addr = {NCH{a}}; ev_syn = {NCH{s}};
      @(negedge clk);
      bus_wr = 1'b0; ev_corr = '0; ev_fatal = '0;
   endtask

   task automatic wr(input logic [5:0] idx, input logic [31:0] wd);
      cyc(1'b1, idx, wd, '0, '0, 32'h0, 8'h0);
   endtask

   task automatic rd(input logic [5:0] idx, output logic [31:0] d);
      bus_idx = idx;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int i = 0; i < 4; i++) begin
         rd(6'(i), d); chk("R1 reset ctrl word", d, 32'h0);
      end
      rd(6'd48, d); chk("R1 reset counter", d, 32'h0);
      chk("R10 reset irq", {30'b0, irq_corr, irq_fatal}, 32'h0);
   endtask

   task automatic t_enable;
      logic [31:0] d;
      wr(6'd0, 32'hFFFF_FFFF);
      rd(6'd0, d); chk("R2 enable low readback", d, 32'hCCCC_CCCC);
      wr(6'd1, 32'h8000_0003);
      rd(6'd1, d); chk("R1 channel 8 nibble, bits 1:0 zero", d, 32'h8000_0000);
      chk("R10 no flags no irq", {30'b0, irq_corr, irq_fatal}, 32'h0);
      wr(6'd0, 32'h0); wr(6'd1, 32'h0);
      rd(6'd0, d); chk("R2 enable cleared", d, 32'h0);
   endtask

   task automatic t_corr_ch3;
      logic [31:0] d;
      cyc(1'b0, 6'd0, 32'h0, 16'h0008, 16'h0, 32'h1234_5678, 8'h5A);
      rd(6'd2, d);  chk("R3 R1 channel 3 corr flag at bit 19", d, 32'h0008_0000);
      rd(6'd51, d); chk("R7 channel 3 count", d, 32'd1);
      rd(6'd19, d); chk("R6 channel 3 address", d, 32'h1234_5678);
      rd(6'd35, d); chk("R6 channel 3 syndrome", d, 32'h0000_005A);
      chk("R10 disabled irq stays low", {31'b0, irq_corr}, 32'h0);
      wr(6'd0, 32'h0008_0000);
      chk("R10 enabled flag raises irq_corr", {31'b0, irq_corr}, 32'h1);
      wr(6'd2, 32'h0004_0000);
      rd(6'd2, d); chk("R4 other bit write keeps flag", d, 32'h0008_0000);
      wr(6'd2, 32'h0);
      rd(6'd2, d); chk("R4 zero write keeps flag", d, 32'h0008_0000);
      wr(6'd2, 32'h0008_0000);
      rd(6'd2, d); chk("R4 one write clears flag", d, 32'h0);
      chk("R10 irq_corr drops", {31'b0, irq_corr}, 32'h0);
      wr(6'd0, 32'h0);
      cyc(1'b0, 6'd0, 32'h0, 16'h0008, 16'h0, 32'hAAAA_0001, 8'h11);
      cyc(1'b0, 6'd0, 32'h0, 16'h0008, 16'h0, 32'hBBBB_0002, 8'h22);
      rd(6'd19, d); chk("R6 latest address wins", d, 32'hBBBB_0002);
      rd(6'd35, d); chk("R6 latest syndrome wins", d, 32'h0000_0022);
      rd(6'd51, d); chk("R7 count after three events", d, 32'd3);
      wr(6'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_fatal_ch12;
      logic [31:0] d;
      cyc(1'b0, 6'd0, 32'h0, 16'h0, 16'h1000, 32'hDEAD_0C0C, 8'h77);
      rd(6'd3, d);  chk("R3 R1 channel 12 fatal flag at bit 14", d, 32'h0000_4000);
      rd(6'd60, d); chk("R7 fatal event not counted", d, 32'd0);
      rd(6'd28, d); chk("R6 fatal event address", d, 32'hDEAD_0C0C);
      rd(6'd44, d); chk("R6 fatal event syndrome", d, 32'h0000_0077);
      wr(6'd1, 32'h0000_4000);
      chk("R10 irq_fatal high, irq_corr low", {30'b0, irq_corr, irq_fatal}, 32'h1);
      wr(6'd3, 32'h0000_4000);
      chk("R10 irq_fatal drops after clear", {31'b0, irq_fatal}, 32'h0);
      wr(6'd1, 32'h0);
   endtask

   task automatic t_race_ch0;
      logic [31:0] d;
      cyc(1'b0, 6'd0, 32'h0, 16'h0001, 16'h0, 32'h0, 8'h0);
      rd(6'd2, d); chk("R1 channel 0 flag at bit 31", d, 32'h8000_0000);
      cyc(1'b1, 6'd2, 32'h8000_0000, 16'h0001, 16'h0, 32'h0, 8'h0);
      rd(6'd2, d); chk("R5 event beats clear", d, 32'h8000_0000);
      wr(6'd2, 32'h8000_0000);
      rd(6'd2, d); chk("R4 clear after race", d, 32'h0);
   endtask

   task automatic t_counter_ch5;
      logic [31:0] d;
      for (int i = 0; i < 260; i++) cyc(1'b0, 6'd0, 32'h0, 16'h0020, 16'h0, 32'h0, 8'h0);
      rd(6'd53, d); chk("R8 counter saturates at 255", d, 32'd255);
      wr(6'd53, 32'd7);
      rd(6'd53, d); chk("R9 nonzero write ignored", d, 32'd255);
      wr(6'd53, 32'd0);
      rd(6'd53, d); chk("R9 zero write resets", d, 32'd0);
      cyc(1'b0, 6'd0, 32'h0, 16'h0020, 16'h0, 32'h0, 8'h0);
      cyc(1'b0, 6'd0, 32'h0, 16'h0020, 16'h0, 32'h0, 8'h0);
      cyc(1'b1, 6'd53, 32'h0, 16'h0020, 16'h0, 32'h0, 8'h0);
      rd(6'd53, d); chk("R9 reset with event gives one", d, 32'd1);
      wr(6'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_both_ch15;
      logic [31:0] d;
      cyc(1'b0, 6'd0, 32'h0, 16'h8000, 16'h8000, 32'h0F0F_0F0F, 8'h33);
      rd(6'd3, d);  chk("R11 both flags at bits 3:2", d, 32'h0000_000C);
      rd(6'd63, d); chk("R11 counted once", d, 32'd1);
      rd(6'd2, d);  chk("R1 low flags untouched", d, 32'h0);
   endtask

   initial begin
      #400000;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_enable();
      t_corr_ch3();
      t_fatal_ch12();
      t_race_ch0();
      t_counter_ch5();
      t_both_ch15();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule